// File: doc/BRIEF.md
# Serial Link Bring-up and Health Supervisor

This block supervises one point-to-point serial link channel. It walks the link through a staged two-way handshake: the local PHY comes into sync, the far end reports that its PHY is in sync, then the far end confirms that it sees ours. While the handshake is incomplete it asks the frame sender to emit a SYNC frame at a programmable millisecond period. Each of these frames carries the local stage flags. Flags decoded from received SYNC frames drive the stage forward. Missing frames, or a frame whose flags show the far end has lost sync, drive it back.

Link health comes from a leaky error bucket. Every bad packet adds a programmable weight, and every good packet drains one unit. When the bucket rises above a programmable threshold, the link is reported as not ok. If automatic recovery is enabled, the same condition raises a fixed-length PHY reset pulse. Loss of PHY sync does the same. The block also accepts a one-shot reset, which fires on a rising edge, and a level-held manual reset. It counts every reset pulse and reports how many milliseconds the current stage has lasted. All timeouts, weights and thresholds are run-time inputs, and `ms_tick` supplies the millisecond time base.

Top module: `lnk_health_sup`

## Requirements
- R1: The stage goes from idle to PHY-synced when `phy_sync` is high. It goes from PHY-synced to rx-synced on a SYNC frame whose flag bit 0 is set. It goes from rx-synced to up on a SYNC frame whose flag bit 1 is set. `sync_flags` is {up, rx-synced or up, not idle} on bits 2,1,0. `link_ok` is high only when the stage is up and the error bucket is not above `err_thresh`.
- R2: In the PHY-synced and rx-synced stages, `sync_req` pulses for one cycle every `resend_ms` ticks. It never pulses in the idle or up stages.
- R3: In the rx-synced or up stage, the stage falls back to PHY-synced when either of two things happens: `sync_to_ms` ticks pass without a SYNC frame or good packet, or a SYNC frame arrives with flag bit 0 clear.
- R4: `remote_link_ok` follows flag bit 2 of the latest SYNC frame. It clears in the idle stage and on a receive timeout.
- R5: `time_valid` sets on a time frame while the stage is up. It clears after `time_to_ms` ticks without one, or when the stage leaves up.
- R6: A bad packet adds `err_step` to the bucket, saturating at its maximum and never wrapping. A good packet alone removes 1, saturating at zero. When both arrive in the same cycle, the bad packet wins.
- R7: With `auto_rst_en` high, two conditions start a PHY reset pulse: the bucket is above threshold, or `phy_sync` is low outside the idle stage. The pulse keeps `phy_rst` high for 16 cycles. While it lasts, the stage is idle and the bucket is cleared. `phy_rst_cnt` increments by one for each pulse.
- R8: A 0-to-1 edge of `oneshot_rst` starts exactly one such pulse. Holding the input high starts no further pulse.
- R9: While `man_rst` is high, `phy_rst` is high and the stage is held idle. The counter does not change.
- R10: `stat_clr` sets `phy_rst_cnt` to zero and leaves the stage unchanged.
- R11: `state_ms` counts ticks since the last stage change. It restarts at zero on every change.
- R12: One cycle after `ena` is low, the stage is idle and `sync_req` is low.
- R13: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ena | input | 1 | Channel enable |
| phy_sync | input | 1 | Local PHY synchronized |
| sync_rx_stb | input | 1 | A SYNC frame was received this cycle |
| sync_rx_flags | input | 3 | Flags of that frame, same encoding as `sync_flags` |
| time_rx_stb | input | 1 | A time frame was received this cycle |
| pkt_good | input | 1 | A good packet was received this cycle |
| pkt_bad | input | 1 | A bad packet was received this cycle |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| resend_ms | input | TW | SYNC resend period in ticks |
| sync_to_ms | input | TW | SYNC receive timeout in ticks |
| time_to_ms | input | TW | Time frame timeout in ticks |
| err_step | input | SW | Bucket weight of one bad packet |
| err_thresh | input | EW | Bucket level above which the link is bad |
| auto_rst_en | input | 1 | Enable automatic PHY reset |
| man_rst | input | 1 | Level-held PHY reset |
| oneshot_rst | input | 1 | Edge-triggered single PHY reset |
| stat_clr | input | 1 | Clear the reset counter |
| sync_req | output | 1 | Request to send a SYNC frame |
| sync_flags | output | 3 | Local stage flags to place in SYNC frames |
| link_ok | output | 1 | Link up and healthy |
| remote_link_ok | output | 1 | Far end reports link up |
| time_valid | output | 1 | Time frames arriving in time |
| phy_rst | output | 1 | PHY reset request |
| phy_rst_cnt | output | CW | Number of reset pulses |
| state_ms | output | 32 | Ticks spent in the current stage |

## Verification
The assertions assume that `ms_tick` is a single-cycle strobe and that run-time settings do not change in the same cycle as the events that compare against them. They also assume every input is synchronous to `clk`. The stimulus keeps to this by doing two things. It drives every input at the falling edge. It raises `ms_tick` for exactly one cycle in four and changes settings only while no packet or frame strobe is active. Receive strobes are one-cycle pulses. The one exception is `pkt_bad`, which is held high for a long burst on purpose to push the bucket into saturation.

// File: rtl/lnk_sup_pkg.sv
package lnk_sup_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PHY  = 2'd1,
      ST_RXS  = 2'd2,
      ST_UP   = 2'd3
   } lnk_st_e;

   // bit positions inside the SYNC flag field
   localparam int unsigned FLG_PHY = 0;
   localparam int unsigned FLG_RX  = 1;
   localparam int unsigned FLG_UP  = 2;
   localparam int unsigned FLG_W   = 3;

   // power-on values for the run-time settings
   localparam int unsigned DEF_RESEND_MS  = 107;
   localparam int unsigned DEF_SYNC_TO_MS = 2000;
   localparam int unsigned DEF_TIME_TO_MS = 3000;
   localparam int unsigned DEF_ERR_STEP   = 10;
   localparam int unsigned DEF_ERR_THRESH = 99;

endpackage

// File: rtl/lnk_tick_cnt.sv
module lnk_tick_cnt #(
   parameter int W   = 16,
   parameter bit SAT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         tick,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] ONE = W'(1);

   if (W < 2) begin : g_w_bad
      $error("lnk_tick_cnt: W must be at least 2");
   end

   if (SAT) begin : g_sat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   cnt <= '0;
         else if (clr)                 cnt <= '0;
         else if (tick && cnt != '1)   cnt <= cnt + ONE;
      end
   end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    cnt <= '0;
         else if (clr)  cnt <= '0;
         else if (tick) cnt <= cnt + ONE;
      end
   end
endmodule

// File: rtl/lnk_err_bucket.sv
module lnk_err_bucket #(
   parameter int EW = 16,
   parameter int SW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          bad_pkt,
   input  logic          good_pkt,
   input  logic [SW-1:0] step,
   input  logic [EW-1:0] thresh,
   output logic          over
);
   localparam logic [EW-1:0] ONE = EW'(1);

   if (SW > EW) begin : g_w_bad
      $error("lnk_err_bucket: SW must not exceed EW");
   end

   logic [EW-1:0] lvl_q;
   logic [EW:0]   sum;

   assign sum  = {1'b0, lvl_q} + {{(EW + 1 - SW){1'b0}}, step};
   assign over = lvl_q > thresh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        lvl_q <= '0;
      else if (clr)                      lvl_q <= '0;
      else if (bad_pkt)                  lvl_q <= sum[EW] ? '1 : sum[EW-1:0];
      else if (good_pkt && lvl_q != '0)  lvl_q <= lvl_q - ONE;
   end

   // R6
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_pkt && !clr) |=> (lvl_q >= $past(lvl_q)));
endmodule

// File: rtl/lnk_rst_ctrl.sv
module lnk_rst_ctrl #(
   parameter int RST_CYC = 16,
   parameter int CW      = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          auto_trig,
   input  logic          osh_in,
   input  logic          man_rst,
   input  logic          stat_clr,
   output logic          pulse_act,
   output logic          rst_o,
   output logic [CW-1:0] rst_cnt
);
   localparam int            PW     = $clog2(RST_CYC + 1);
   localparam logic [PW-1:0] P_LEN  = PW'(RST_CYC);
   localparam logic [PW-1:0] P_ONE  = PW'(1);
   localparam logic [CW-1:0] C_ONE  = CW'(1);

   if (RST_CYC < 2) begin : g_len_bad
      $error("lnk_rst_ctrl: RST_CYC must be at least 2");
   end

   logic          osh_q;
   logic [PW-1:0] pc_q;
   logic          start;

   assign pulse_act = pc_q != '0;
   assign start     = !pulse_act && (auto_trig || (osh_in && !osh_q));
   assign rst_o     = pulse_act || man_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         osh_q   <= 1'b0;
         pc_q    <= '0;
         rst_cnt <= '0;
      end else begin
         osh_q <= osh_in;
         if (start)          pc_q <= P_LEN;
         else if (pulse_act) pc_q <= pc_q - P_ONE;
         if (stat_clr)       rst_cnt <= '0;
         else if (start)     rst_cnt <= rst_cnt + C_ONE;
      end
   end

   // length of the last pulse, for the checks below
   logic [PW-1:0] hl_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hl_q <= '0;
      else if (pulse_act) hl_q <= hl_q + P_ONE;
      else                hl_q <= '0;
   end

   // R7
   pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pulse_act) |-> (hl_q == P_LEN));

   // R10
   cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_clr |=> (rst_cnt == '0));
endmodule

// File: rtl/lnk_health_sup.sv
module lnk_health_sup
   import lnk_sup_pkg::*;
#(
   parameter int TW      = 16,
   parameter int EW      = 16,
   parameter int SW      = 8,
   parameter int CW      = 32,
   parameter int RST_CYC = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ena,
   input  logic          phy_sync,
   input  logic          sync_rx_stb,
   input  logic [2:0]    sync_rx_flags,
   input  logic          time_rx_stb,
   input  logic          pkt_good,
   input  logic          pkt_bad,
   input  logic          ms_tick,
   input  logic [TW-1:0] resend_ms,
   input  logic [TW-1:0] sync_to_ms,
   input  logic [TW-1:0] time_to_ms,
   input  logic [SW-1:0] err_step,
   input  logic [EW-1:0] err_thresh,
   input  logic          auto_rst_en,
   input  logic          man_rst,
   input  logic          oneshot_rst,
   input  logic          stat_clr,
   output logic          sync_req,
   output logic [2:0]    sync_flags,
   output logic          link_ok,
   output logic          remote_link_ok,
   output logic          time_valid,
   output logic          phy_rst,
   output logic [CW-1:0] phy_rst_cnt,
   output logic [31:0]   state_ms
);
   localparam logic [TW:0] T_ONE = (TW + 1)'(1);

   lnk_st_e       st_q, st_d;
   logic [TW-1:0] resend_cnt, sync_age, time_age;
   logic          bad, pulse_act, hold_idle, handshaking, in_link;
   logic          sync_to_hit, fire, auto_trig, frame_ok, frame_lost;

   assign handshaking = (st_q == ST_PHY) || (st_q == ST_RXS);
   assign in_link     = (st_q == ST_RXS) || (st_q == ST_UP);
   assign sync_to_hit = in_link && (sync_age >= sync_to_ms);
   assign hold_idle   = !ena || pulse_act || man_rst || !phy_sync;
   assign frame_ok    = sync_rx_stb && sync_rx_flags[FLG_PHY];
   assign frame_lost  = sync_rx_stb && !sync_rx_flags[FLG_PHY];
   assign fire        = ena && ms_tick && handshaking &&
                        (({1'b0, resend_cnt} + T_ONE) >= {1'b0, resend_ms});
   assign auto_trig   = auto_rst_en && (bad || (st_q != ST_IDLE && !phy_sync));

   // R1 R3: stage sequencing
   always_comb begin
      st_d = st_q;
      if (hold_idle) st_d = ST_IDLE;
      else begin
         unique case (st_q)
            ST_IDLE: st_d = ST_PHY;
            ST_PHY:  if (frame_ok) st_d = ST_RXS;
            ST_RXS:  if (sync_to_hit || frame_lost) st_d = ST_PHY;
                     else if (sync_rx_stb && sync_rx_flags[FLG_RX]) st_d = ST_UP;
            ST_UP:   if (sync_to_hit || frame_lost) st_d = ST_PHY;
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q           <= ST_IDLE;
         sync_req       <= 1'b0;
         remote_link_ok <= 1'b0;
         time_valid     <= 1'b0;
      end else begin
         st_q     <= st_d;
         sync_req <= fire;
         // R4
         if (st_q == ST_IDLE || sync_to_hit) remote_link_ok <= 1'b0;
         else if (sync_rx_stb)               remote_link_ok <= sync_rx_flags[FLG_UP];
         // R5
         if (st_q != ST_UP)                  time_valid <= 1'b0;
         else if (time_rx_stb)               time_valid <= 1'b1;
         else if (time_age >= time_to_ms)    time_valid <= 1'b0;
      end
   end

   // R2 resend period, R3 receive age, R5 time age, R11 stage time
   lnk_tick_cnt #(.W(TW), .SAT(1'b1)) u_resend (
      .clk(clk), .rst_n(rst_n), .clr(!handshaking || fire),
      .tick(ms_tick), .cnt(resend_cnt));

   lnk_tick_cnt #(.W(TW), .SAT(1'b1)) u_sync_age (
      .clk(clk), .rst_n(rst_n),
      .clr(st_q == ST_IDLE || sync_rx_stb || pkt_good || sync_to_hit),
      .tick(ms_tick), .cnt(sync_age));

   lnk_tick_cnt #(.W(TW), .SAT(1'b1)) u_time_age (
      .clk(clk), .rst_n(rst_n), .clr(st_q != ST_UP || time_rx_stb),
      .tick(ms_tick), .cnt(time_age));

   lnk_tick_cnt #(.W(32), .SAT(1'b1)) u_state_ms (
      .clk(clk), .rst_n(rst_n), .clr(st_d != st_q),
      .tick(ms_tick), .cnt(state_ms));

   // R6
   lnk_err_bucket #(.EW(EW), .SW(SW)) u_bucket (
      .clk(clk), .rst_n(rst_n), .clr(pulse_act),
      .bad_pkt(pkt_bad), .good_pkt(pkt_good),
      .step(err_step), .thresh(err_thresh), .over(bad));

   // R7 R8 R9 R10
   lnk_rst_ctrl #(.RST_CYC(RST_CYC), .CW(CW)) u_rst (
      .clk(clk), .rst_n(rst_n), .auto_trig(auto_trig),
      .osh_in(oneshot_rst), .man_rst(man_rst), .stat_clr(stat_clr),
      .pulse_act(pulse_act), .rst_o(phy_rst), .rst_cnt(phy_rst_cnt));

   assign sync_flags[FLG_PHY] = st_q != ST_IDLE;
   assign sync_flags[FLG_RX]  = in_link;
   assign sync_flags[FLG_UP]  = st_q == ST_UP;
   assign link_ok             = (st_q == ST_UP) && !bad;

   // R1
   stage_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_UP) |-> ($past(st_q) == ST_RXS || $past(st_q) == ST_UP));

   // R12
   ena_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ena |=> (st_q == ST_IDLE && !sync_req));

   // R9
   man_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      man_rst |=> (st_q == ST_IDLE));
endmodule

// File: tb/lnk_health_sup_tb.sv
`timescale 1ns/1ps
module lnk_health_sup_tb;
   import lnk_sup_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ena = 1'b1, phy_sync = 1'b0, sync_rx_stb = 1'b0, time_rx_stb = 1'b0;
   logic [2:0] sync_rx_flags = 3'b000;
   logic pkt_good = 1'b0, pkt_bad = 1'b0, ms_tick = 1'b0;
   logic [15:0] resend_ms = 16'(DEF_RESEND_MS), sync_to_ms = 16'(DEF_SYNC_TO_MS);
   logic [15:0] time_to_ms = 16'(DEF_TIME_TO_MS), err_thresh = 16'(DEF_ERR_THRESH);
   logic [7:0]  err_step = 8'(DEF_ERR_STEP);
   logic auto_rst_en = 1'b1, man_rst = 1'b0, oneshot_rst = 1'b0, stat_clr = 1'b0;

   logic        sync_req, link_ok, remote_link_ok, time_valid, phy_rst;
   logic [2:0]  sync_flags;
   logic [31:0] phy_rst_cnt, state_ms;

   always #4 clk = ~clk;

   lnk_health_sup u_dut (
      .clk(clk), .rst_n(rst_n), .ena(ena), .phy_sync(phy_sync),
      .sync_rx_stb(sync_rx_stb), .sync_rx_flags(sync_rx_flags),
      .time_rx_stb(time_rx_stb), .pkt_good(pkt_good), .pkt_bad(pkt_bad),
      .ms_tick(ms_tick), .resend_ms(resend_ms), .sync_to_ms(sync_to_ms),
      .time_to_ms(time_to_ms), .err_step(err_step), .err_thresh(err_thresh),
      .auto_rst_en(auto_rst_en), .man_rst(man_rst), .oneshot_rst(oneshot_rst),
      .stat_clr(stat_clr), .sync_req(sync_req), .sync_flags(sync_flags),
      .link_ok(link_ok), .remote_link_ok(remote_link_ok), .time_valid(time_valid),
      .phy_rst(phy_rst), .phy_rst_cnt(phy_rst_cnt), .state_ms(state_ms));

   // behavioural reference
   int     m_st = 0, m_rcnt = 0, m_sage = 0, m_tage = 0, m_err = 0, m_pc = 0, nst;
   bit     m_tv = 0, m_rl = 0, m_oq = 0, m_sreq = 0;
   bit     b_bad, b_hold, b_inl, b_hit, b_fire, b_start;
   longint m_rc = 0, m_sms = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_rcnt = 0; m_sage = 0; m_tage = 0; m_err = 0; m_pc = 0;
         m_tv = 0; m_rl = 0; m_oq = 0; m_sreq = 0; m_rc = 0; m_sms = 0;
      end else begin
         b_bad  = m_err > int'(err_thresh);
         b_inl  = (m_st == 2) || (m_st == 3);
         b_hit  = b_inl && (m_sage >= int'(sync_to_ms));
         b_hold = !ena || (m_pc != 0) || man_rst || !phy_sync;
         if (b_hold) nst = 0;
         else if (m_st == 0) nst = 1;
         else if (m_st == 1) nst = (sync_rx_stb && sync_rx_flags[0]) ? 2 : 1;
         else if (b_hit || (sync_rx_stb && !sync_rx_flags[0])) nst = 1;
         else if (m_st == 2 && sync_rx_stb && sync_rx_flags[1]) nst = 3;
         else nst = m_st;
         b_fire  = ena && ms_tick && (m_st == 1 || m_st == 2) && (m_rcnt + 1 >= int'(resend_ms));
         b_start = (m_pc == 0) &&
                   ((auto_rst_en && (b_bad || (m_st != 0 && !phy_sync))) || (oneshot_rst && !m_oq));
         m_sreq = b_fire;
         if (!(m_st == 1 || m_st == 2) || b_fire) m_rcnt = 0;
         else if (ms_tick && m_rcnt < 65535) m_rcnt++;
         if (m_st == 0 || sync_rx_stb || pkt_good || b_hit) m_sage = 0;
         else if (ms_tick && m_sage < 65535) m_sage++;
         if (m_st == 0 || b_hit) m_rl = 0;
         else if (sync_rx_stb) m_rl = sync_rx_flags[2];
         if (m_st != 3) m_tv = 0;
         else if (time_rx_stb) m_tv = 1;
         else if (m_tage >= int'(time_to_ms)) m_tv = 0;
         if (m_st != 3 || time_rx_stb) m_tage = 0;
         else if (ms_tick && m_tage < 65535) m_tage++;
         if (m_pc != 0) m_err = 0;
         else if (pkt_bad) m_err = (m_err + int'(err_step) > 65535) ? 65535 : m_err + int'(err_step);
         else if (pkt_good && m_err > 0) m_err--;
         if (b_start) m_pc = 16;
         else if (m_pc > 0) m_pc--;
         if (stat_clr) m_rc = 0;
         else if (b_start) m_rc = (m_rc + 1) & 64'hFFFF_FFFF;
         if (nst != m_st) m_sms = 0;
         else if (ms_tick && m_sms < 64'hFFFF_FFFF) m_sms++;
         m_oq = oneshot_rst;
         m_st = nst;
      end
   end

   int vecs = 0, fails = 0, cyc = 0, sreq_seen = 0;

   task automatic chk(string tag, string what, longint act, longint exp);
      vecs++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R2",  "sync_req",       sync_req, m_sreq);
      chk("R1",  "sync_flags",     sync_flags,
          {m_st == 3, (m_st == 2 || m_st == 3), m_st != 0});
      chk("R6",  "link_ok",        link_ok, (m_st == 3) && !(m_err > int'(err_thresh)));
      chk("R4",  "remote_link_ok", remote_link_ok, m_rl);
      chk("R5",  "time_valid",     time_valid, m_tv);
      chk("R7",  "phy_rst",        phy_rst, (m_pc != 0) || man_rst);
      chk("R10", "phy_rst_cnt",    phy_rst_cnt, m_rc);
      chk("R11", "state_ms",       state_ms, m_sms);
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare_all();
         if (sync_req) sreq_seen++;
         cyc++;
         ms_tick = (cyc % 4 == 3);
      end
   endtask

   task automatic send_sync(logic [2:0] f);
      sync_rx_flags = f; sync_rx_stb = 1'b1;
      run(1);
      sync_rx_stb = 1'b0;
      run(2);
   endtask

   task automatic pulse_good();
      pkt_good = 1'b1; run(1); pkt_good = 1'b0;
   endtask

   task automatic pulse_bad();
      pkt_bad = 1'b1; run(1); pkt_bad = 1'b0;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   int s0;

   initial begin
      run(3);
      // R13 reset state
      chk("R13", "reset outputs",
          {sync_req, sync_flags, link_ok, remote_link_ok, time_valid, phy_rst}, 0);
      chk("R13", "reset counters", phy_rst_cnt + state_ms, 0);
      rst_n = 1'b1;
      run(2);

      // R1 R2 handshake with periodic resend
      phy_sync = 1'b1;
      sreq_seen = 0;
      run(1000);
      chk("R2", "resends in handshake", sreq_seen, 2);
      chk("R1", "phy stage flags", sync_flags, 3'b001);
      send_sync(3'b001);
      chk("R1", "rx stage flags", sync_flags, 3'b011);
      send_sync(3'b011);
      chk("R1", "up flags", sync_flags, 3'b111);
      chk("R1", "link up", link_ok, 1);
      sreq_seen = 0;
      run(1000);
      chk("R2", "no resend when up", sreq_seen, 0);
      send_sync(3'b111);
      chk("R4", "remote link ok", remote_link_ok, 1);

      // R5 time validity and its timeout
      time_rx_stb = 1'b1; run(1); time_rx_stb = 1'b0; run(2);
      chk("R5", "time valid set", time_valid, 1);
      for (int k = 0; k < 13; k++) begin pulse_good(); run(999); end
      chk("R5", "time valid dropped", time_valid, 0);
      chk("R5", "link still up", link_ok, 1);

      // R3 receive timeout falls back to the phy stage
      run(8500);
      chk("R3", "fallback flags", sync_flags, 3'b001);
      chk("R4", "remote cleared on timeout", remote_link_ok, 0);

      // R6 error bucket
      send_sync(3'b001); send_sync(3'b011);
      auto_rst_en = 1'b0;
      for (int k = 0; k < 10; k++) begin pulse_bad(); run(1); end
      chk("R6", "bucket 100 over 99", link_ok, 0);
      pkt_bad = 1'b1; pkt_good = 1'b1; run(1);
      pkt_bad = 1'b0; pkt_good = 1'b0; run(1);
      for (int k = 0; k < 10; k++) begin pulse_good(); run(1); end
      chk("R6", "bucket 100 after bad-wins cycle", link_ok, 0);
      pulse_good(); run(1);
      chk("R6", "bucket back to 99", link_ok, 1);
      err_step = 8'd255; err_thresh = 16'd65534;
      run(1);
      pkt_bad = 1'b1; run(300); pkt_bad = 1'b0; run(1);
      chk("R6", "bucket saturates, no wrap", link_ok, 0);

      // R7 automatic reset from a bad link
      err_thresh = 16'(DEF_ERR_THRESH); err_step = 8'(DEF_ERR_STEP);
      auto_rst_en = 1'b1;
      run(2);
      chk("R7", "auto pulse high", phy_rst, 1);
      chk("R7", "counter one", phy_rst_cnt, 1);
      run(20);
      chk("R7", "pulse ended, stage phy", sync_flags, 3'b001);

      // R8 one-shot on a rising edge only
      oneshot_rst = 1'b1; run(40);
      chk("R8", "held high, single pulse", phy_rst_cnt, 2);
      chk("R8", "pulse over", phy_rst, 0);
      oneshot_rst = 1'b0; run(2);
      oneshot_rst = 1'b1; run(1); oneshot_rst = 1'b0; run(30);
      chk("R8", "second edge, second pulse", phy_rst_cnt, 3);

      // R9 manual reset
      man_rst = 1'b1; run(50);
      chk("R9", "manual holds reset", phy_rst, 1);
      chk("R9", "manual holds idle", sync_flags, 3'b000);
      chk("R9", "manual not counted", phy_rst_cnt, 3);
      man_rst = 1'b0; run(3);

      // R7 lost PHY sync while up
      send_sync(3'b001); send_sync(3'b011);
      phy_sync = 1'b0; run(2);
      chk("R7", "sync loss pulse", phy_rst, 1);
      chk("R7", "sync loss counted", phy_rst_cnt, 4);
      phy_sync = 1'b1; run(30);

      // R10 statistics clear keeps the stage
      send_sync(3'b001); send_sync(3'b011);
      stat_clr = 1'b1; run(1); stat_clr = 1'b0; run(1);
      chk("R10", "counter cleared", phy_rst_cnt, 0);
      chk("R10", "stage kept", sync_flags, 3'b111);

      // R11 stage timer
      run(5);
      s0 = int'(state_ms);
      run(40);
      chk("R11", "ten ticks in stage", state_ms, s0 + 10);
      send_sync(3'b000);
      chk("R11", "restart on change", state_ms, 0);

      // R12 channel disable
      ena = 1'b0; run(2);
      chk("R12", "disabled idle", sync_flags, 3'b000);
      sreq_seen = 0;
      run(1000);
      chk("R12", "disabled sends nothing", sreq_seen, 0);

      summary();
      $finish;
   end
endmodule